// File: doc/BRIEF.md
# Seven-Segment Multilevel Switching Sequencer

This block turns one located space-vector triangle into the gate commands of a three-phase, five-level cascaded H-bridge inverter. For each switching period it receives three dwell times (two active, one zero), the orientation of the triangle (base at the bottom or at the top), the sector of the reference vector and the base switching state of the triangle. The base state is one signed level per phase in the range -2 to +2. The block then plays out a symmetric seven-segment sequence of three-phase states. Each state is the base state plus a small per-phase offset of -1, 0 or +1. The state is clamped, rotated and sign-inverted according to the sector, and finally encoded as the eight gate bits of each phase leg.

A period counter inside the block measures the segments in clock cycles. A one-cycle load strobe offers a new set of inputs. The set is never applied in the middle of a period. It waits in a pending slot until the current period ends, and then the next period starts with it. With no new load, the last set is replayed period after period. The intended operating point is an 18 kHz switching frequency under a 50 Hz fundamental. The cycles per period therefore follow from the system clock and the dwell times supplied.

Top module: `sevenseg_seq`

## Requirements
- R1: After reset, and until the first period starts, every phase sits at level 0. Its gate byte is 8'h3C.
- R2: Bit n of a gate byte drives switch n+1. A phase at signed level v uses k = v+2 (0..4) and sets bits 4-k up to 7-k, with all other bits clear. Level +2 gives 8'h0F, level -2 gives 8'hF0, and exactly four adjacent bits are set at all times.
- R3: The segment lengths in cycles, in segment order, are zero/4, a/2, b/2, zero/2, b/2, a/2 and zero/4, each rounded down. A segment of length zero is skipped. If all seven are zero, a period lasts one cycle and shows segment 4.
- R4: With tri_down = 0, the per-phase offsets over segments 1..7 are ONN, OON, OOO, POO, OOO, OON, ONN. Here O = +0, N = -1 and P = +1, applied to phases a, b, c of the base state.
- R5: With tri_down = 1, the offsets over segments 1..7 are POO, OOO, OON, ONN, OON, OOO, POO.
- R6: Segments 5, 6 and 7 repeat segments 3, 2 and 1. Within one period the segment number never goes back.
- R7: Let (x, y, z) be the offset triangle state for phases a, b, c. The outputs for phases a, b, c are then: sector 1 (x,y,z); sector 2 (-y,-z,-x); sector 3 (z,x,y); sector 4 (-x,-y,-z); sector 5 (y,z,x); sector 6 (-z,-x,-y).
- R8: Sector codes 0 and 7 behave as sector 1.
- R9: Base plus offset is clamped to the range -2..+2 before the sector mapping.
- R10: A load during a period has no visible effect until that period ends. Inputs that change without a load are ignored. With no new load, the active set repeats.
- R11: A load in the last cycle of a period, or while idle, starts the next period with that set on the following clock edge. When several loads arrive in one period, the latest one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe offering a new parameter set |
| t_a | input | 16 | First active dwell time, cycles |
| t_b | input | 16 | Second active dwell time, cycles |
| t_zero | input | 16 | Zero-vector dwell time, cycles |
| tri_down | input | 1 | 0: base-at-bottom triangle, 1: base-at-top triangle |
| sector | input | 3 | Sector 1..6 |
| base_a | input | 4 | Signed base level of phase a |
| base_b | input | 4 | Signed base level of phase b |
| base_c | input | 4 | Signed base level of phase c |
| gate_a | output | 8 | Gate bits of phase a leg |
| gate_b | output | 8 | Gate bits of phase b leg |
| gate_c | output | 8 | Gate bits of phase c leg |

## Verification
A behavioural model predicts all three gate bytes on every cycle. Directed runs first separate the two triangle orientations: their offset orders differ, and so do the mirror points. Each of the six sectors, plus the two unused codes, is then applied to an asymmetric base state (+1, 0, -1), so that any wrong rotation or missing inversion is visible on a specific phase. Dwell sets with odd values and zeros test the rounding, the skipping of segments and the one-cycle period. Loads placed in mid-period, back to back, and followed by input changes without a strobe separate deferred latching from immediate use. A long run with random loads, parameters and out-of-range bases then makes loads coincide with period ends and drives the clamp from both sides.

// File: rtl/sevenseg_pkg.sv
package sevenseg_pkg;

    localparam int NSEG    = 7;
    localparam int MID_SEG = 3;

    // offset pattern slot for a segment: 0=ONN 1=OON 2=OOO 3=POO
    function automatic logic [1:0] pattern_slot(input logic [2:0] seg, input logic down);
        logic [1:0] m;
        m = (seg <= 3'd3) ? seg[1:0] : 2'(3'd6 - seg);
        return down ? (2'd3 - m) : m;
    endfunction

    // phase rotation amount of a sector (unused codes act as sector 1)
    function automatic logic [1:0] sector_rot(input logic [2:0] sec);
        case (sec)
            3'd2, 3'd5: return 2'd1;
            3'd3, 3'd6: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic sector_neg(input logic [2:0] sec);
        return (sec == 3'd2) || (sec == 3'd4) || (sec == 3'd6);
    endfunction

endpackage

// File: rtl/sevenseg_ctrl.sv
module sevenseg_ctrl
    import sevenseg_pkg::*;
#(
    parameter  int TW = 16,
    parameter  int LW = 4,
    localparam int PW = TW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] t_a,
    input  logic [TW-1:0] t_b,
    input  logic [TW-1:0] t_zero,
    input  logic          tri_down,
    input  logic [2:0]    sector,
    input  logic [LW-1:0] base_a,
    input  logic [LW-1:0] base_b,
    input  logic [LW-1:0] base_c,
    output logic          run,
    output logic          boundary,
    output logic [2:0]    seg,
    output logic          act_down,
    output logic [2:0]    act_sector,
    output logic [LW-1:0] act_base_a,
    output logic [LW-1:0] act_base_b,
    output logic [LW-1:0] act_base_c
);

    typedef struct packed {
        logic [TW-1:0] ta;
        logic [TW-1:0] tb;
        logic [TW-1:0] t0;
        logic          dn;
        logic [2:0]    sec;
        logic [LW-1:0] ba;
        logic [LW-1:0] bb;
        logic [LW-1:0] bc;
    } prm_t;

    typedef struct packed {
        logic          run;
        logic          pv;
        logic [PW-1:0] cnt;
        prm_t          act;
        prm_t          pend;
    } st_t;

    st_t           st_d, st_q;
    prm_t          incoming;
    logic [PW-1:0] dur [NSEG];
    logic [PW-1:0] plen, last, acc;
    logic          bnd, found;
    logic [2:0]    seg_c;

    always_comb begin
        incoming.ta  = t_a;
        incoming.tb  = t_b;
        incoming.t0  = t_zero;
        incoming.dn  = tri_down;
        incoming.sec = sector;
        incoming.ba  = base_a;
        incoming.bb  = base_b;
        incoming.bc  = base_c;

        // symmetric segment lengths of the active set
        dur[0] = PW'(st_q.act.t0 >> 2);
        dur[1] = PW'(st_q.act.ta >> 1);
        dur[2] = PW'(st_q.act.tb >> 1);
        dur[3] = PW'(st_q.act.t0 >> 1);
        dur[4] = dur[2];
        dur[5] = dur[1];
        dur[6] = dur[0];

        plen = '0;
        for (int i = 0; i < NSEG; i++) begin
            plen = plen + dur[i];
        end
        last = (plen == '0) ? '0 : plen - 1'b1;
        bnd  = !st_q.run || (st_q.cnt == last);

        // current segment: first cumulative bound above the count
        acc   = '0;
        found = 1'b0;
        seg_c = 3'(MID_SEG);
        for (int i = 0; i < NSEG; i++) begin
            acc = acc + dur[i];
            if (!found && (st_q.cnt < acc)) begin
                seg_c = 3'(i);
                found = 1'b1;
            end
        end

        st_d = st_q;
        if (bnd) begin
            st_d.cnt = '0;
            if (load) begin
                st_d.act = incoming;
                st_d.run = 1'b1;
                st_d.pv  = 1'b0;
            end else if (st_q.pv) begin
                st_d.act = st_q.pend;
                st_d.run = 1'b1;
                st_d.pv  = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (load) begin
                st_d.pend = incoming;
                st_d.pv   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run        = st_q.run;
    assign boundary   = bnd;
    assign seg        = seg_c;
    assign act_down   = st_q.act.dn;
    assign act_sector = st_q.act.sec;
    assign act_base_a = st_q.act.ba;
    assign act_base_b = st_q.act.bb;
    assign act_base_c = st_q.act.bc;

endmodule

// File: rtl/sevenseg_phase.sv
module sevenseg_phase
    import sevenseg_pkg::*;
#(
    parameter  int CELLS = 4,
    parameter  int LW    = 4,
    localparam int KW    = $clog2(CELLS + 1),
    localparam int HALF  = CELLS / 2
) (
    input  logic          run,
    input  logic [2:0]    seg,
    input  logic          down,
    input  logic [2:0]    sector,
    input  logic [LW-1:0] base_a,
    input  logic [LW-1:0] base_b,
    input  logic [LW-1:0] base_c,
    output logic [KW-1:0] lvl [3]
);

    localparam logic signed [LW:0] HI = (LW + 1)'(HALF);
    localparam logic signed [LW:0] LO = -HI;

    function automatic logic signed [LW:0] clamp(input logic signed [LW:0] v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    logic [1:0]         slot, rot;
    logic               neg;
    logic signed [LW:0] off [3];
    logic signed [LW:0] tri_l [3];
    logic signed [LW:0] out_l [3];
    logic signed [LW:0] k_s;

    always_comb begin
        slot = pattern_slot(seg, down);
        rot  = sector_rot(sector);
        neg  = sector_neg(sector);

        off[0] = (slot == 2'd3) ? (LW + 1)'(1) : '0;
        off[1] = (slot == 2'd0) ? -(LW + 1)'(1) : '0;
        off[2] = (slot <= 2'd1) ? -(LW + 1)'(1) : '0;

        tri_l[0] = clamp($signed({base_a[LW-1], base_a}) + off[0]);
        tri_l[1] = clamp($signed({base_b[LW-1], base_b}) + off[1]);
        tri_l[2] = clamp($signed({base_c[LW-1], base_c}) + off[2]);

        for (int p = 0; p < 3; p++) begin
            case (rot)
                2'd1:    out_l[p] = tri_l[(p + 1) % 3];
                2'd2:    out_l[p] = tri_l[(p + 2) % 3];
                default: out_l[p] = tri_l[p];
            endcase
            if (neg) begin
                out_l[p] = -out_l[p];
            end
        end

        for (int p = 0; p < 3; p++) begin
            k_s    = run ? (out_l[p] + HI) : HI;
            lvl[p] = KW'(k_s);
        end
    end

endmodule

// File: rtl/sevenseg_leg.sv
module sevenseg_leg #(
    parameter  int CELLS = 4,
    localparam int KW    = $clog2(CELLS + 1),
    localparam int GW    = 2 * CELLS
) (
    input  logic [KW-1:0] level,
    output logic [GW-1:0] gates
);

    int lo;

    always_comb begin
        lo = CELLS - int'(level);
        for (int n = 0; n < GW; n++) begin
            gates[n] = (n >= lo) && (n < lo + CELLS);
        end
    end

endmodule

// File: rtl/sevenseg_seq.sv
module sevenseg_seq #(
    parameter  int CELLS = 4,
    parameter  int TW    = 16,
    localparam int LW    = $clog2(CELLS + 1) + 1,
    localparam int KW    = $clog2(CELLS + 1),
    localparam int GW    = 2 * CELLS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [TW-1:0]        t_a,
    input  logic [TW-1:0]        t_b,
    input  logic [TW-1:0]        t_zero,
    input  logic                 tri_down,
    input  logic [2:0]           sector,
    input  logic signed [LW-1:0] base_a,
    input  logic signed [LW-1:0] base_b,
    input  logic signed [LW-1:0] base_c,
    output logic [GW-1:0]        gate_a,
    output logic [GW-1:0]        gate_b,
    output logic [GW-1:0]        gate_c
);

    logic          run_w, bnd_w, act_dn_w;
    logic [2:0]    seg_w, act_sec_w;
    logic [LW-1:0] act_ba_w, act_bb_w, act_bc_w;
    logic [KW-1:0] lvl_w [3];
    logic [GW-1:0] gate_w [3];

    sevenseg_ctrl #(.TW(TW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .t_a        (t_a),
        .t_b        (t_b),
        .t_zero     (t_zero),
        .tri_down   (tri_down),
        .sector     (sector),
        .base_a     (base_a),
        .base_b     (base_b),
        .base_c     (base_c),
        .run        (run_w),
        .boundary   (bnd_w),
        .seg        (seg_w),
        .act_down   (act_dn_w),
        .act_sector (act_sec_w),
        .act_base_a (act_ba_w),
        .act_base_b (act_bb_w),
        .act_base_c (act_bc_w)
    );

    sevenseg_phase #(.CELLS(CELLS), .LW(LW)) u_phase (
        .run    (run_w),
        .seg    (seg_w),
        .down   (act_dn_w),
        .sector (act_sec_w),
        .base_a (act_ba_w),
        .base_b (act_bb_w),
        .base_c (act_bc_w),
        .lvl    (lvl_w)
    );

    for (genvar p = 0; p < 3; p++) begin : g_leg
        sevenseg_leg #(.CELLS(CELLS)) u_leg (
            .level (lvl_w[p]),
            .gates (gate_w[p])
        );
    end

    assign gate_a = gate_w[0];
    assign gate_b = gate_w[1];
    assign gate_c = gate_w[2];

endmodule

// File: rtl/sevenseg_seq_chk.sv
module sevenseg_seq_chk #(
    parameter  int CELLS = 4,
    localparam int GW    = 2 * CELLS
) (
    input logic          clk,
    input logic          rst_n,
    input logic [GW-1:0] gate_a,
    input logic [GW-1:0] gate_b,
    input logic [GW-1:0] gate_c,
    input logic          run,
    input logic          boundary,
    input logic [2:0]    seg,
    input logic [2:0]    act_sector,
    input logic          act_down
);

    localparam logic [GW-1:0] ZERO_PAT = GW'(((1 << CELLS) - 1) << (CELLS / 2));

    // R2: one contiguous window of CELLS switches on each leg
    a_r2_window_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_a) == CELLS) && ($countones(gate_a & (gate_a >> 1)) == CELLS - 1));
    a_r2_window_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_b) == CELLS) && ($countones(gate_b & (gate_b >> 1)) == CELLS - 1));
    a_r2_window_c: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_c) == CELLS) && ($countones(gate_c & (gate_c >> 1)) == CELLS - 1));

    // R1: idle legs rest at the middle level
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (gate_a == ZERO_PAT) && (gate_b == ZERO_PAT) && (gate_c == ZERO_PAT));

    // R6: segment number never goes back inside a period
    a_r6_seg_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !boundary) |=> (seg >= $past(seg)));

    // R3: only seven segments exist
    a_r3_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
        seg <= 3'd6);

    // R10: the active set is held through a period
    a_r10_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !boundary) |=> $stable(act_sector) && $stable(act_down));

    // R11: once running, the sequencer keeps running
    a_r11_stay_run: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

endmodule

bind sevenseg_seq sevenseg_seq_chk #(.CELLS(CELLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .gate_c     (gate_c),
    .run        (run_w),
    .boundary   (bnd_w),
    .seg        (seg_w),
    .act_sector (act_sec_w),
    .act_down   (act_dn_w)
);

// File: tb/sevenseg_seq_bench.sv
module sevenseg_seq_bench;

    localparam int CLK_NS   = 10;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [15:0]       t_a = '0, t_b = '0, t_zero = '0;
    logic              tri_down = 1'b0;
    logic [2:0]        sector = 3'd1;
    logic signed [3:0] base_a = '0, base_b = '0, base_c = '0;
    logic [7:0]        gate_a, gate_b, gate_c;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    sevenseg_seq u_sevenseg_seq (
        .clk(clk), .rst_n(rst_n), .load(load),
        .t_a(t_a), .t_b(t_b), .t_zero(t_zero),
        .tri_down(tri_down), .sector(sector),
        .base_a(base_a), .base_b(base_b), .base_c(base_c),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
    );

    always #(CLK_NS / 2) clk = ~clk;

    typedef struct { int ta, tb, t0, dn, sec, ba, bb, bc; } prm_t;

    prm_t m_act, m_pend;
    bit   m_run = 1'b0, m_pv = 1'b0;
    int   m_cnt = 0;

    function automatic prm_t sample_in();
        prm_t p;
        p.ta = int'(t_a);  p.tb = int'(t_b);  p.t0 = int'(t_zero);
        p.dn = int'(tri_down); p.sec = int'(sector);
        p.ba = int'(base_a); p.bb = int'(base_b); p.bc = int'(base_c);
        return p;
    endfunction

    function automatic int seg_len(prm_t p, int s);
        case (s)
            0, 6: return p.t0 / 4;
            1, 5: return p.ta / 2;
            2, 4: return p.tb / 2;
            default: return p.t0 / 2;
        endcase
    endfunction

    function automatic int period_len(prm_t p);
        int sum = 0;
        for (int s = 0; s < 7; s++) sum += seg_len(p, s);
        return sum;
    endfunction

    function automatic int seg_at(prm_t p, int c);
        int acc = 0;
        for (int s = 0; s < 7; s++) begin
            acc += seg_len(p, s);
            if (c < acc) return s;
        end
        return 3;
    endfunction

    function automatic int clampv(int v);
        if (v > 2) return 2;
        if (v < -2) return -2;
        return v;
    endfunction

    function automatic logic [7:0] window(int v);
        logic [7:0] g;
        int k = v + 2;
        for (int n = 0; n < 8; n++) g[n] = (n >= 4 - k) && (n <= 7 - k);
        return g;
    endfunction

    function automatic void expect_gates(output logic [7:0] ga, gb, gc);
        int s, m, a, b, c, x, y, z, sec;
        if (!m_run) begin
            ga = 8'h3C; gb = 8'h3C; gc = 8'h3C;
            return;
        end
        s = seg_at(m_act, m_cnt);
        m = (s <= 3) ? s : 6 - s;
        if (m_act.dn != 0) m = 3 - m;
        a = clampv(m_act.ba + ((m == 3) ? 1 : 0));
        b = clampv(m_act.bb - ((m == 0) ? 1 : 0));
        c = clampv(m_act.bc - ((m <= 1) ? 1 : 0));
        sec = (m_act.sec < 1 || m_act.sec > 6) ? 1 : m_act.sec;
        case (sec)
            1: begin x = a;  y = b;  z = c;  end
            2: begin x = -b; y = -c; z = -a; end
            3: begin x = c;  y = a;  z = b;  end
            4: begin x = -a; y = -b; z = -c; end
            5: begin x = b;  y = c;  z = a;  end
            default: begin x = -c; y = -a; z = -b; end
        endcase
        ga = window(x); gb = window(y); gc = window(z);
    endfunction

    // reference model, one step per clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 1'b0; m_pv = 1'b0; m_cnt = 0;
        end else begin
            int plen, lastc;
            bit bnd;
            plen  = period_len(m_act);
            lastc = (plen == 0) ? 0 : plen - 1;
            bnd   = !m_run || (m_cnt == lastc);
            if (bnd) begin
                m_cnt = 0;
                if (load) begin
                    m_act = sample_in(); m_run = 1'b1; m_pv = 1'b0;
                end else if (m_pv) begin
                    m_act = m_pend; m_run = 1'b1; m_pv = 1'b0;
                end
            end else begin
                m_cnt = m_cnt + 1;
                if (load) begin
                    m_pend = sample_in(); m_pv = 1'b1;
                end
            end
        end
    end

    task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %02h expected %02h at %0t", req, what, got, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] ea, eb, ec;
            expect_gates(ea, eb, ec);
            check(cur_req, "gate_a", gate_a, ea);
            check(cur_req, "gate_b", gate_b, eb);
            check(cur_req, "gate_c", gate_c, ec);
        end
    end

    task automatic drive(int ta, int tb, int t0, int dn, int sec, int ba, int bb, int bc);
        @(negedge clk);
        t_a = 16'(ta); t_b = 16'(tb); t_zero = 16'(t0);
        tri_down = dn[0]; sector = 3'(sec);
        base_a = 4'(ba); base_b = 4'(bb); base_c = 4'(bc);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset and idle state
        repeat (3) @(negedge clk);
        check("R1", "gate_a in reset", gate_a, 8'h3C);
        check("R1", "gate_c in reset", gate_c, 8'h3C);
        rst_n = 1'b1;
        idle(4);
        check("R1", "gate_b idle", gate_b, 8'h3C);

        // R4 R9 R2: first segment of a base-at-bottom set, literal values
        cur_req = "R4";
        drive(6, 4, 8, 0, 1, 2, -2, 0);
        check("R2", "gate_a level +2", gate_a, 8'h0F);
        check("R9", "gate_b clamped -2", gate_b, 8'hF0);
        check("R4", "gate_c ONN", gate_c, 8'h78);
        idle(40);

        cur_req = "R5";
        drive(6, 4, 8, 1, 1, 0, 0, 0);
        idle(40);

        // R7: every sector on an asymmetric base, both orientations
        cur_req = "R7";
        for (int s = 1; s <= 6; s++) begin
            drive(5, 7, 9, s % 2, s, 1, 0, -1);
            idle(22);
        end

        cur_req = "R8";
        drive(4, 6, 8, 0, 0, 1, 0, -1);
        idle(22);
        drive(4, 6, 8, 1, 7, 1, 0, -1);
        idle(22);

        // R3: rounding, skipped segments, one-cycle periods
        cur_req = "R3";
        drive(0, 0, 0, 0, 1, 0, 1, -1);
        idle(8);
        drive(3, 1, 1, 0, 2, 0, 1, -1);
        idle(10);
        drive(1, 5, 3, 1, 3, 1, 1, 0);
        idle(12);

        // R10: mid-period load, unstrobed input changes ignored
        cur_req = "R10";
        drive(10, 10, 12, 0, 1, 0, 0, 0);
        idle(5);
        drive(4, 4, 4, 1, 4, 1, -1, 0);
        @(negedge clk);
        sector = 3'd5; tri_down = 1'b0; base_a = 4'sd2;
        idle(40);

        // R11: back-to-back loads, latest wins
        cur_req = "R11";
        drive(8, 8, 8, 0, 2, 0, 0, 1);
        drive(6, 6, 6, 1, 6, -1, 1, 0);
        idle(30);

        // R6: random loads landing on any cycle of a period
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            t_a = 16'($urandom % 12); t_b = 16'($urandom % 12); t_zero = 16'($urandom % 16);
            tri_down = 1'($urandom % 2); sector = 3'($urandom % 8);
            base_a = 4'(int'($urandom % 7) - 3);
            base_b = 4'(int'($urandom % 7) - 3);
            base_c = 4'(int'($urandom % 7) - 3);
            load = (($urandom % 8) == 0);
        end
        @(negedge clk);
        load = 1'b0;
        idle(20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule